// File: doc/BRIEF.md
# Seeded LFSR Random Word Generator

This block is the core of a random number peripheral. A one-bit entropy stream, already synchronous to a dedicated generator clock, is folded into the feedback of a 32-bit linear feedback shift register. Once the register has absorbed enough fresh seed bits since its last hand-off, its contents are passed across to the bus clock domain through a synchronized toggle handshake. There the word lands in a read-only data register and a data-ready flag is raised.

Software sees three word-aligned registers: control, status and data. The status word reports data ready, the live state and the sticky state of two fault conditions, and drives an interrupt when interrupts are enabled. One fault is a seed-pattern fault, which the block detects itself. The other is a clock-rate fault, which arrives as an input. A seed fault freezes generation, and only a disable followed by a re-enable restarts it.

Top module: `seeded_rng`

## Requirements
- R1: Control lives at byte offset 0x00, with bit 3 the interrupt enable and bit 2 the generator enable. Every other control bit reads as 0. Control, status and data all read as zero after reset. The full address is compared, and offset 0x0C reads zero.
- R2: Status lives at 0x04, with bit 0 data ready, bit 1 live clock fault, bit 2 live seed fault, bit 5 sticky clock fault and bit 6 sticky seed fault. Other status bits read 0, and writes cannot set data ready. Data lives at 0x08 and ignores writes.
- R3: A read of offset 0x08 while data ready is 1 leaves data ready at 0 from the following bus cycle.
- R4: While generation is healthy, data ready is set again within 40 generator-clock periods after a data read.
- R5: The sticky seed flag rises with the live seed fault bit. Only a write of 0 to status bit 6 clears it, and only while the live bit is 0. Writing 1 to it leaves it unchanged.
- R6: Status bit 1 follows the clock fault input. The sticky clock flag (bit 5) is set on the bus cycle after that input is 1. The same written-zero rule as R5 clears it, and a live fault wins over a clear.
- R7: The interrupt output is 1 exactly when the interrupt enable is 1 and any of data ready, bit 5 or bit 6 is 1.
- R8: While the live seed fault is 1, data ready is held at 0 and no new word is delivered.
- R9: A seed fault stays in force through any seed input until the generator enable is cleared. After the enable is set again, words are produced afresh.
- R10: A seed fault is declared after 64 consecutive equal seed bits, or after 64 consecutive bits that each differ from the bit before them (32 alternating pairs). A run of 63 of either kind raises no fault.
- R11: The register starts from 0x00000001 on enable. On each enabled generator-clock rising edge it shifts left, taking into bit 0 the XOR of bits 31, 21, 1 and 0 with the seed bit sampled at that edge. Each delivered word is a register state reached after at least 32 absorbed bits since the previous hand-off.
- R12: While the generator enable is 0, data ready stays 0 and no word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| gen_clk | input | 1 | Generator clock |
| gen_rst | input | 1 | Synchronous active-high reset, generator domain |
| seed_in | input | 1 | Entropy bit, synchronous to gen_clk |
| clk_fault_in | input | 1 | Live clock-rate fault indication, bus domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data reads) |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the fault detector's edge, where 63 identical or alternating bits must pass and 64 must trip. Random entropy never produces runs that long. The bench therefore drives the seed port from a queue of exact bit patterns and falls back to a short pseudo-random sequence once the queue is empty. This lets it place runs of exactly 63 and of more than 64 bits in both forms. The shift register's start edge depends on synchronizer latency, so delivered words are checked against a set of register states. That set is built by several reference registers started at successive generator edges after enable.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int ADDR_W = 4;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_DATA = 4'h8;

    localparam int CTRL_IE = 3;
    localparam int CTRL_EN = 2;

    localparam int ST_RDY = 0;
    localparam int ST_CFC = 1;
    localparam int ST_SFC = 2;
    localparam int ST_CFS = 5;
    localparam int ST_SFS = 6;

    // x^32 + x^22 + x^2 + x + 1 as feedback taps on bits 31, 21, 1, 0
    localparam logic [WORD_W-1:0] LFSR_TAPS = 32'h8020_0003;
    localparam logic [WORD_W-1:0] LFSR_INIT = 32'h0000_0001;

    typedef struct packed {
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic seed_sticky;
        logic clk_sticky;
        logic seed_now;
        logic clk_now;
        logic ready;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e reg_decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CTRL: return SEL_CTRL;
            OFF_STAT: return SEL_STAT;
            OFF_DATA: return SEL_DATA;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s,
                                                    input logic b);
        return {s[WORD_W-2:0], (^(s & LFSR_TAPS)) ^ b};
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_IE] = c.ie;
        w[CTRL_EN] = c.en;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] stat_word(input stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_RDY] = s.ready;
        w[ST_CFC] = s.clk_now;
        w[ST_SFC] = s.seed_now;
        w[ST_CFS] = s.clk_sticky;
        w[ST_SFS] = s.seed_sticky;
        return w;
    endfunction

endpackage

// File: rtl/rng_sync.sv
module rng_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rng_seed_mon.sv
module rng_seed_mon #(
    parameter int RUN_LIMIT = 64
) (
    input  logic gen_clk,
    input  logic gen_rst,
    input  logic en,
    input  logic seed,
    output logic fault
);
    localparam int CNT_W = $clog2(RUN_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LIMIT);

    logic             prev_q;
    logic             have_q;
    logic [CNT_W-1:0] eq_cnt;
    logic [CNT_W-1:0] alt_cnt;
    logic             fault_q;

    logic             same;
    logic [CNT_W-1:0] eq_nx;
    logic [CNT_W-1:0] alt_nx;

    always_comb begin
        same   = (seed == prev_q);
        eq_nx  = eq_cnt + 1'b1;
        alt_nx = alt_cnt + 1'b1;
    end

    always_ff @(posedge gen_clk) begin
        if (gen_rst || !en) begin
            prev_q  <= 1'b0;
            have_q  <= 1'b0;
            eq_cnt  <= '0;
            alt_cnt <= '0;
            fault_q <= 1'b0;
        end else if (!fault_q) begin
            prev_q <= seed;
            have_q <= 1'b1;
            if (!have_q) begin
                eq_cnt  <= CNT_W'(1);
                alt_cnt <= CNT_W'(1);
            end else if (same) begin
                eq_cnt  <= eq_nx;
                alt_cnt <= CNT_W'(1);
                if (eq_nx >= LIMIT) fault_q <= 1'b1;
            end else begin
                alt_cnt <= alt_nx;
                eq_cnt  <= CNT_W'(1);
                if (alt_nx >= LIMIT) fault_q <= 1'b1;
            end
        end
    end

    assign fault = fault_q;
endmodule

// File: rtl/rng_gen.sv
module rng_gen
    import rng_pkg::*;
#(
    parameter int XFER_BITS = 32
) (
    input  logic              gen_clk,
    input  logic              gen_rst,
    input  logic              en,
    input  logic              fault,
    input  logic              seed,
    input  logic              ack_t,
    output logic              req_t,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(XFER_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(XFER_BITS);

    logic [WORD_W-1:0] lfsr_q;
    logic [WORD_W-1:0] hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              req_q;
    logic              xfer;

    assign xfer = (cnt_q == FULL) && (req_q == ack_t);

    always_ff @(posedge gen_clk) begin
        if (gen_rst) begin
            lfsr_q <= LFSR_INIT;
            hold_q <= '0;
            cnt_q  <= '0;
            req_q  <= 1'b0;
        end else if (!en) begin
            lfsr_q <= LFSR_INIT;
            cnt_q  <= '0;
        end else if (!fault) begin
            lfsr_q <= lfsr_next(lfsr_q, seed);
            if (xfer) begin
                hold_q <= lfsr_q;
                req_q  <= ~req_q;
                cnt_q  <= CNT_W'(1);
            end else if (cnt_q != FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign req_t = req_q;
    assign word  = hold_q;
endmodule

// File: rtl/seeded_rng.sv
module seeded_rng
    import rng_pkg::*;
#(
    parameter int XFER_BITS   = 32,
    parameter int RUN_LIMIT   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_clk,
    input  logic              gen_rst,
    input  logic              seed_in,
    input  logic              clk_fault_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              ready_q;
    logic              clk_sticky_q;
    logic              seed_sticky_q;
    logic [WORD_W-1:0] data_q;
    logic              ack_q;

    logic              en_g;
    logic              gen_fault;
    logic              req_t;
    logic              req_b;
    logic              ack_g;
    logic              seed_now_b;
    logic [WORD_W-1:0] gen_word;

    logic              wr_ctrl, wr_stat, rd_data;
    logic              pending, capture, discard;
    stat_t             st;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[WORD_W-1:7], wdata[4], wdata[1:0]};

    // generator clock domain
    rng_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk(gen_clk), .rst(gen_rst), .d(ctrl_q.en), .q(en_g)
    );
    rng_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(gen_clk), .rst(gen_rst), .d(ack_q), .q(ack_g)
    );
    rng_seed_mon #(.RUN_LIMIT(RUN_LIMIT)) u_mon (
        .gen_clk(gen_clk), .gen_rst(gen_rst), .en(en_g),
        .seed(seed_in), .fault(gen_fault)
    );
    rng_gen #(.XFER_BITS(XFER_BITS)) u_gen (
        .gen_clk(gen_clk), .gen_rst(gen_rst), .en(en_g), .fault(gen_fault),
        .seed(seed_in), .ack_t(ack_g), .req_t(req_t), .word(gen_word)
    );

    // bus clock domain
    rng_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_t), .q(req_b)
    );
    rng_sync #(.STAGES(SYNC_STAGES)) u_flt_sync (
        .clk(clk), .rst(rst), .d(gen_fault), .q(seed_now_b)
    );

    always_comb begin
        wr_ctrl = wr_en && (addr == OFF_CTRL);
        wr_stat = wr_en && (addr == OFF_STAT);
        rd_data = rd_en && (addr == OFF_DATA);
        pending = (req_b != ack_q);
        discard = pending && (!ctrl_q.en || seed_now_b);
        capture = pending && !discard && !ready_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q        <= '0;
            ready_q       <= 1'b0;
            clk_sticky_q  <= 1'b0;
            seed_sticky_q <= 1'b0;
            data_q        <= '0;
            ack_q         <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ie <= wdata[CTRL_IE];
                ctrl_q.en <= wdata[CTRL_EN];
            end
            clk_sticky_q  <= clk_fault_in |
                             (clk_sticky_q & ~(wr_stat & ~wdata[ST_CFS]));
            seed_sticky_q <= seed_now_b |
                             (seed_sticky_q & ~(wr_stat & ~wdata[ST_SFS]));
            if (discard || capture) ack_q <= req_b;
            if (capture) data_q <= gen_word;
            if (!ctrl_q.en || seed_now_b) ready_q <= 1'b0;
            else if (capture)             ready_q <= 1'b1;
            else if (rd_data)             ready_q <= 1'b0;
        end
    end

    always_comb begin
        st.ready       = ready_q;
        st.clk_now     = clk_fault_in;
        st.seed_now    = seed_now_b;
        st.clk_sticky  = clk_sticky_q;
        st.seed_sticky = seed_sticky_q;
        case (reg_decode(addr))
            SEL_CTRL: rdata = ctrl_word(ctrl_q);
            SEL_STAT: rdata = stat_word(st);
            SEL_DATA: rdata = data_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = ctrl_q.ie & (ready_q | clk_sticky_q | seed_sticky_q);

endmodule

// File: rtl/rng_chk.sv
module rng_chk
    import rng_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gen_clk,
    input logic              gen_rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata_sfs,
    input logic              clk_fault_in,
    input logic              irq,
    input logic              ie,
    input logic              en,
    input logic              ready,
    input logic              seed_sticky,
    input logic              clk_sticky,
    input logic              seed_now,
    input logic              gen_fault,
    input logic              gen_en
);
    a_r3_ready_drops_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_DATA && ready) |=> !ready);

    a_r5_seed_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (seed_sticky && !(wr_en && addr == OFF_STAT && !wdata_sfs)) |=> seed_sticky);

    a_r6_clk_sticky_sets: assert property (@(posedge clk) disable iff (rst)
        clk_fault_in |=> clk_sticky);

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

    a_r8_no_ready_in_fault: assert property (@(posedge clk) disable iff (rst)
        seed_now |=> !ready);

    a_r9_fault_latched: assert property (@(posedge gen_clk) disable iff (gen_rst)
        (gen_fault && gen_en) |=> gen_fault);

    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !ready);
endmodule

bind seeded_rng rng_chk u_chk (
    .clk(clk), .rst(rst), .gen_clk(gen_clk), .gen_rst(gen_rst),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata_sfs(wdata[6]),
    .clk_fault_in(clk_fault_in), .irq(irq), .ie(ctrl_q.ie), .en(ctrl_q.en),
    .ready(ready_q), .seed_sticky(seed_sticky_q), .clk_sticky(clk_sticky_q),
    .seed_now(seed_now_b), .gen_fault(gen_fault), .gen_en(en_g)
);

// File: tb/sim_seeded_rng.sv
module sim_seeded_rng;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_DATA = 4'h8;

    logic        clk = 0, gen_clk = 0;
    logic        rst = 1, gen_rst = 1;
    logic        seed = 0, cfault = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [3:0]  addr = A_STAT;
    logic [31:0] wdata = 0;
    wire  [31:0] rdata;
    wire         irq;

    int total = 0, bad = 0;
    bit done = 0;
    bit ie_m = 0;

    always #2 clk = ~clk;      // 250 MHz bus clock
    always #4 gen_clk = ~gen_clk;

    seeded_rng u0 (
        .clk(clk), .rst(rst), .gen_clk(gen_clk), .gen_rst(gen_rst),
        .seed_in(seed), .clk_fault_in(cfault), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // seed source: queued exact patterns, else a short pseudo-random stream
    bit          seed_q[$];
    logic [15:0] prbs = 16'hACE1;
    always @(negedge gen_clk) begin
        if (seed_q.size() > 0) seed <= seed_q.pop_front();
        else begin
            prbs <= {prbs[14:0], prbs[15] ^ prbs[13] ^ prbs[12] ^ prbs[10]};
            seed <= prbs[0];
        end
    end

    // reference registers started at successive generator edges
    logic [31:0] mdl [8];
    int  gcount = 0, restart_n = 0, restart_done = 0;
    bit  seen [logic [31:0]];

    function automatic logic [31:0] ref_step(logic [31:0] s, logic b);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0] ^ b};
    endfunction

    always @(posedge gen_clk) begin
        if (restart_n != restart_done) begin
            for (int j = 0; j < 8; j++) mdl[j] = 32'h1;
            seen.delete();
            gcount = 0;
            restart_done = restart_n;
        end else if (restart_done > 0) begin
            for (int j = 0; j < 8; j++)
                if (gcount >= j) begin
                    mdl[j] = ref_step(mdl[j], seed);
                    seen[mdl[j]] = 1'b1;
                end
            gcount++;
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0; addr = A_STAT;
        if (a == A_CTRL) ie_m = d[3];
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0; addr = A_STAT;
    endtask

    task automatic wait_ready(int maxc, output int cyc);
        for (cyc = 0; cyc < maxc; cyc++) begin
            @(negedge clk); #1;
            if (rdata[0]) break;
        end
    endtask

    task automatic drain_seed();
        while (seed_q.size() > 0) @(negedge gen_clk);
        repeat (4) @(negedge gen_clk);
        repeat (4) @(negedge clk);
    endtask

    // every-clock comparison of interrupt and live clock fault (R7, R6)
    always @(negedge clk) begin
        #1;
        if (!rst && !done && addr == A_STAT && !rd_en) begin
            check(irq == (ie_m & (rdata[0] | rdata[5] | rdata[6])), "R7 irq",
                  {31'b0, irq}, {31'b0, ie_m & (rdata[0] | rdata[5] | rdata[6])});
            check(rdata[1] == cfault, "R6 live clock bit", {31'b0, rdata[1]}, {31'b0, cfault});
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev;
        int cyc;
        repeat (6) @(negedge clk);
        rst = 0; gen_rst = 0;
        repeat (2) @(negedge clk);

        // reset state
        bus_read(A_CTRL, v); check(v == 0, "R1 ctrl reset", v, 0);
        bus_read(A_STAT, v); check(v == 0, "R2 status reset", v, 0);
        bus_read(A_DATA, v); check(v == 0, "R2 data reset", v, 0);
        bus_read(4'hC, v);   check(v == 0, "R1 unused offset", v, 0);
        check(irq == 0, "R7 irq reset", {31'b0, irq}, 0);

        // interrupt enable only
        bus_write(A_CTRL, 32'h0000_0008);
        bus_read(A_CTRL, v); check(v == 32'h8, "R1 ie only", v, 32'h8);
        repeat (40) @(negedge clk);
        bus_read(A_STAT, v); check(v[0] == 0, "R12 no word while disabled", v, 0);

        // enable with junk bits
        restart_n++;
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read(A_CTRL, v); check(v == 32'hC, "R1 ctrl mask", v, 32'hC);
        wait_ready(300, cyc); check(cyc < 300, "R11 first word", cyc, 0);
        bus_read(A_DATA, v); check(seen.exists(v), "R11 word in state set", v, 0);
        prev = v;
        bus_read(A_STAT, v); check(v[0] == 0, "R3 ready cleared", v, 0);

        for (int k = 0; k < 5; k++) begin
            wait_ready(200, cyc);
            check(cyc <= 80, "R4 refill time", cyc, 80);
            bus_read(A_DATA, v);
            check(seen.exists(v), "R11 word in state set", v, 0);
            check(v != prev, "R11 fresh word", v, prev);
            prev = v;
        end

        // writes to data and ready are ignored
        wait_ready(200, cyc);
        bus_write(A_DATA, 32'hFFFF_FFFF);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check(v[0] == 1, "R2 ready not writable", v, 1);
        bus_read(A_DATA, v); check(seen.exists(v), "R2 data not writable", v, 0);

        // clock fault
        cfault = 1; repeat (3) @(negedge clk);
        bus_read(A_STAT, v); check((v & 32'h22) == 32'h22, "R6 fault set", v, 32'h22);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check(v[5] == 1, "R6 live fault wins", v, 32'h20);
        cfault = 0; repeat (3) @(negedge clk);
        bus_read(A_STAT, v); check((v & 32'h22) == 32'h20, "R6 sticky kept", v, 32'h20);
        bus_write(A_STAT, 32'h20);
        bus_read(A_STAT, v); check(v[5] == 1, "R6 write one keeps", v, 32'h20);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check(v[5] == 0, "R6 write zero clears", v, 0);

        // interrupt gating
        wait_ready(200, cyc);
        bus_write(A_CTRL, 32'h4);
        check(irq == 0, "R7 irq masked", {31'b0, irq}, 0);
        bus_write(A_CTRL, 32'hC);
        check(irq == 1, "R7 irq on ready", {31'b0, irq}, 1);

        // 63 equal bits: no fault
        seed_q.push_back(0);
        for (int i = 0; i < 63; i++) seed_q.push_back(1);
        seed_q.push_back(0);
        drain_seed();
        bus_read(A_STAT, v); check((v & 32'h44) == 0, "R10 run of 63 equal", v, 0);

        // 63 alternating bits: no fault
        seed_q.push_back(1); seed_q.push_back(1);
        for (int i = 1; i <= 62; i++) seed_q.push_back((i % 2) == 0);
        seed_q.push_back(1);
        drain_seed();
        bus_read(A_STAT, v); check((v & 32'h44) == 0, "R10 run of 63 alternating", v, 0);

        // constant seed: fault
        for (int i = 0; i < 70; i++) seed_q.push_back(0);
        drain_seed();
        bus_read(A_STAT, v); check((v & 32'h45) == 32'h44, "R10 R8 constant fault", v, 32'h44);
        repeat (100) @(negedge clk);
        bus_read(A_STAT, v); check((v & 32'h45) == 32'h44, "R9 R8 fault persists", v, 32'h44);
        bus_write(A_STAT, 32'h40);
        bus_read(A_STAT, v); check(v[6] == 1, "R5 write one keeps", v, 32'h40);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check(v[6] == 1, "R5 live fault wins", v, 32'h40);

        // recovery: disable then enable
        bus_write(A_CTRL, 32'h8);
        repeat (20) @(negedge clk);
        bus_read(A_STAT, v); check((v & 32'h5) == 0, "R9 fault cleared on disable", v, 0);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check(v[6] == 0, "R5 sticky cleared", v, 0);
        repeat (100) @(negedge clk);
        bus_read(A_STAT, v); check(v[0] == 0, "R12 disabled idle", v, 0);
        check(irq == 0, "R7 irq idle", {31'b0, irq}, 0);
        restart_n++;
        bus_write(A_CTRL, 32'hC);
        wait_ready(300, cyc); check(cyc < 300, "R9 restart word", cyc, 0);
        bus_read(A_DATA, v); check(seen.exists(v), "R9 R11 restart word", v, 0);

        // alternating seed: fault
        for (int i = 0; i < 70; i++) seed_q.push_back(i % 2);
        drain_seed();
        bus_read(A_STAT, v); check((v & 32'h45) == 32'h44, "R10 alternating fault", v, 32'h44);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule